// File: doc/BRIEF.md
# MDIO Management Master with Host Register Pair

This block lets a host processor run one management transaction at a time to an external PHY over the two-wire management bus. The host sees two 32-bit registers, chosen by a one-bit select. The command register holds a self-clearing start flag, an operation code, the two programmable low bits of the PHY address and a five-bit PHY register address. The data register carries the outgoing write value in its low half and the most recently read value in its high half.

Setting the start flag with a valid operation code launches a complete frame. The frame is a preamble of ones, the start pattern, the operation code, the PHY address, the register address, a turnaround and sixteen data bits. The block generates the management clock from the system clock with a programmable divider. It launches every output change on the falling clock edge. On reads it releases the data line and captures the PHY's answer on rising clock edges. When the frame ends, the start flag drops to zero, which lets the host poll for completion.

Top module: `mdio_host_master`

## Requirements
- R1: After reset, the command register reads 0x00010000 and the data register reads 0x00000000. A host read returns the selected register (select 0 = command, 1 = data) on `host_rdata` one clock after the select is presented. During reset `host_rdata` is zero.
- R2: Command register layout: start flag at bit 20, operation code at bits 17:16, PHY address low bits at 9:8, register address at 4:0. Data register layout: write value at 15:0, read value at 31:16. The read value cannot be written by the host. All other bits read as zero and ignore writes.
- R3: A host write that sets bit 20 with operation code 01 (write) or 10 (read) starts a frame on the next clock. The start flag reads 1 until the frame ends, then reads 0.
- R4: A frame is sent MSB first in this order: 32 ones; then 0,1; the operation code; PHY address 0,0,0 followed by the two programmed bits; the register address; the turnaround; 16 data bits. On a write, the turnaround is 1,0 and the data is the write value.
- R5: On a read, `mdio_oe` is low from the first turnaround bit to the end of the frame. The 16 data bits are sampled from `mdio_i` at the rising MDC edges. When the frame ends they are loaded MSB first into data bits 31:16.
- R6: If the start flag is set together with operation code 00 or 11, MDC and MDIO stay idle and the start flag reads 0 again one clock later.
- R7: Each frame bit occupies DIV_HALF clocks with MDC low followed by DIV_HALF clocks with MDC high. MDC is low whenever no frame runs. `mdio_o` and `mdio_oe` change only at the clock where MDC falls, or at frame start while MDC is low.
- R8: While the start flag is 1, host writes to either register have no effect.
- R9: `mdio_oe` is low whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe for the selected register |
| host_sel | input | 1 | Register select: 0 command, 1 data |
| host_wdata | input | 32 | Host write value |
| host_rdata | output | 32 | Selected register contents, one clock late |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | Drive enable for the data line (1 = master drives) |
| mdio_i | input | 1 | Management data sampled from the line |

## Verification
The bench builds the block with DIV_HALF = 3. With this value the divider wraps at a count that is not a power of two, and each MDC half period spans more than one clock, so launch on the falling edge and sampling on the rising edge fall on clearly different clocks. At this setting a full frame takes 384 clocks. That leaves room for write frames, read frames fed with pseudo-random line data, both reserved codes and writes attempted while busy. Every clock is compared against a behavioural timing model.

// File: rtl/mdio_host_pkg.sv
package mdio_host_pkg;
  localparam int PRE_BITS   = 32;
  localparam int DATA_W     = 16;
  localparam int PHY_W      = 5;
  localparam int PHY_LO_W   = 2;
  localparam int REG_W      = 5;
  localparam int FRAME_BITS = PRE_BITS + 32;
  localparam int TA_POS     = PRE_BITS + 14;
  localparam int DATA_POS   = PRE_BITS + 16;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  localparam int START_BIT  = 20;
  localparam int OP_LSB     = 16;
  localparam int PHY_LSB    = 8;
  localparam int REG_LSB    = 0;

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  typedef struct packed {
    logic [1:0]          op;
    logic [PHY_LO_W-1:0] phy;
    logic [REG_W-1:0]    regad;
  } mgmt_cmd_t;
endpackage

// File: rtl/mdio_host_clkgen.sv
module mdio_host_clkgen #(
  parameter int DIV_HALF = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick      = run && (cnt == LAST);
  assign rise_tick = tick && !mdc;
  assign fall_tick = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic              host_sel,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              clear_start,
  input  logic              rd_load,
  input  logic [DATA_W-1:0] rd_word,
  output logic              busy,
  output mgmt_cmd_t         cmd,
  output logic [DATA_W-1:0] wr_val
);
  logic [DATA_W-1:0] rd_val;
  logic [31:0]       cmd_word;

  always_comb begin
    cmd_word = '0;
    cmd_word[START_BIT]                  = busy;
    cmd_word[OP_LSB +: 2]                = cmd.op;
    cmd_word[PHY_LSB +: PHY_LO_W]        = cmd.phy;
    cmd_word[REG_LSB +: REG_W]           = cmd.regad;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cmd.op    <= OP_WR;
      cmd.phy   <= '0;
      cmd.regad <= '0;
      wr_val    <= '0;
      rd_val    <= '0;
    end else begin
      if (clear_start) busy <= 1'b0;
      if (rd_load) rd_val <= rd_word;
      if (host_we && !busy) begin
        if (!host_sel) begin
          busy      <= host_wdata[START_BIT];
          cmd.op    <= host_wdata[OP_LSB +: 2];
          cmd.phy   <= host_wdata[PHY_LSB +: PHY_LO_W];
          cmd.regad <= host_wdata[REG_LSB +: REG_W];
        end else begin
          wr_val <= host_wdata[DATA_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else     host_rdata <= host_sel ? {rd_val, wr_val} : cmd_word;
  end
endmodule

// File: rtl/mdio_host_frame.sv
module mdio_host_frame
  import mdio_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  mgmt_cmd_t         cmd,
  input  logic [DATA_W-1:0] wr_val,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              run,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              clear_start,
  output logic              rd_load,
  output logic [DATA_W-1:0] rd_word
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_POS);

  typedef enum logic {ST_IDLE, ST_RUN} state_e;
  state_e state;

  logic [IDX_W-1:0]      bit_idx;
  logic [IDX_W-1:0]      next_idx;
  logic [FRAME_BITS-1:0] shreg;
  logic [FRAME_BITS-1:0] frame_v;
  logic                  is_rd;
  logic                  op_ok;
  logic                  launch;
  logic                  reject;
  logic                  last;
  logic [1:0]            ta;

  assign op_ok    = (cmd.op == OP_WR) || (cmd.op == OP_RD);
  assign launch   = (state == ST_IDLE) && busy && op_ok;
  assign reject   = (state == ST_IDLE) && busy && !op_ok;
  assign last     = (state == ST_RUN) && fall_tick && (bit_idx == LAST_IDX);
  assign next_idx = bit_idx + 1'b1;
  assign ta       = (cmd.op == OP_WR) ? 2'b10 : 2'b00;
  assign frame_v  = {{PRE_BITS{1'b1}}, 2'b01, cmd.op,
                     {(PHY_W-PHY_LO_W){1'b0}}, cmd.phy, cmd.regad, ta, wr_val};

  assign run         = (state == ST_RUN);
  assign clear_start = reject || last;
  assign rd_load     = last && is_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bit_idx <= '0;
      shreg   <= '0;
      is_rd   <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else if (launch) begin
      state   <= ST_RUN;
      bit_idx <= '0;
      shreg   <= frame_v;
      is_rd   <= (cmd.op == OP_RD);
      mdio_o  <= frame_v[FRAME_BITS-1];
      mdio_oe <= 1'b1;
    end else if (last) begin
      state   <= ST_IDLE;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else if (run && fall_tick) begin
      bit_idx <= next_idx;
      shreg   <= shreg << 1;
      mdio_o  <= shreg[FRAME_BITS-2];
      mdio_oe <= !(is_rd && (next_idx >= TA_IDX));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_word <= '0;
    else if (run && rise_tick && is_rd && (bit_idx >= DAT_IDX))
      rd_word <= {rd_word[DATA_W-2:0], mdio_i};
  end
endmodule

// File: rtl/mdio_host_master.sv
module mdio_host_master
  import mdio_host_pkg::*;
#(
  parameter int DIV_HALF = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_we,
  input  logic        host_sel,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic              busy;
  mgmt_cmd_t         cmd;
  logic [DATA_W-1:0] wr_val;
  logic              clear_start;
  logic              rd_load;
  logic [DATA_W-1:0] rd_word;
  logic              run;
  logic              rise_tick;
  logic              fall_tick;

  mdio_host_regs u_regs (
    .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .clear_start(clear_start), .rd_load(rd_load), .rd_word(rd_word),
    .busy(busy), .cmd(cmd), .wr_val(wr_val)
  );

  mdio_host_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk(clk), .rst(rst), .run(run), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_host_frame u_frame (
    .clk(clk), .rst(rst), .busy(busy), .cmd(cmd), .wr_val(wr_val),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .run(run), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .clear_start(clear_start), .rd_load(rd_load), .rd_word(rd_word)
  );
endmodule

// File: rtl/mdio_host_chk.sv
module mdio_host_chk
  import mdio_host_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input mgmt_cmd_t         cmd,
  input logic [DATA_W-1:0] wr_val,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe
);
  a_r7_hold_while_high: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  a_r7_mdc_low_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  a_r9_release_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);

  a_r6_reserved_drop: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && (cmd.op == 2'b00 || cmd.op == 2'b11)) |=> !busy);

  a_r3_valid_holds: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && (cmd.op == OP_WR || cmd.op == OP_RD)) |=> busy);

  a_r8_fields_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(cmd) && $stable(wr_val)));
endmodule

bind mdio_host_master mdio_host_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .cmd(cmd), .wr_val(wr_val),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_host_master_tb.sv
module mdio_host_master_tb;
  localparam int D = 3;
  localparam int FRAME_CLKS = 64 * 2 * D;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic        host_sel = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  mdio_host_master #(.DIV_HALF(D)) u_dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  assign mdio_i = lfsr[0];
  always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit finished = 0, armed = 0;
  string tag = "R1";

  // behavioural model state
  bit          m_start;
  logic [1:0]  m_op, m_phy;
  logic [4:0]  m_reg;
  logic [15:0] m_wd, m_rd, m_rsh;
  logic [63:0] m_frame;
  bit          m_isrd;
  int          m_t = -1;
  logic [31:0] e_rdata;
  logic        e_mdc, e_oe, e_o;

  function automatic logic [31:0] cmd_val();
    return {11'd0, m_start, 2'd0, m_op, 6'd0, m_phy, 3'd0, m_reg};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_start = 0; m_op = 2'b01; m_phy = 0; m_reg = 0; m_wd = 0; m_rd = 0;
      m_t = -1; e_rdata = 0;
    end else begin
      e_rdata = host_sel ? {m_rd, m_wd} : cmd_val();
      if (m_start && m_t < 0) begin
        if (m_op == 2'b01 || m_op == 2'b10) begin
          m_t = 0; m_isrd = (m_op == 2'b10);
          m_frame = {32'hFFFF_FFFF, 2'b01, m_op, 3'b000, m_phy, m_reg,
                     (m_isrd ? 2'b00 : 2'b10), m_wd};
        end else m_start = 0;
      end else if (m_t >= 0) begin
        m_t++;
        if (m_isrd && (m_t % (2*D)) == D && (m_t / (2*D)) >= 48)
          m_rsh = {m_rsh[14:0], mdio_i};
        if (m_t == FRAME_CLKS) begin
          if (m_isrd) m_rd = m_rsh;
          m_start = 0; m_t = -1;
        end
      end else if (host_we) begin
        if (!host_sel) begin
          m_start = host_wdata[20]; m_op = host_wdata[17:16];
          m_phy = host_wdata[9:8]; m_reg = host_wdata[4:0];
        end else m_wd = host_wdata[15:0];
      end
    end
    if (m_t >= 0) begin
      e_mdc = (m_t % (2*D)) >= D;
      e_oe  = !(m_isrd && (m_t / (2*D)) >= 46);
      e_o   = m_frame[63 - m_t / (2*D)];
    end else begin
      e_mdc = 0; e_oe = 0; e_o = 0;
    end
    armed = 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !rst) begin
      chk({tag, " rdata"}, host_rdata, e_rdata);
      chk("R7 mdc", {31'd0, mdc}, {31'd0, e_mdc});
      chk((m_t < 0) ? "R9 oe" : "R5 oe", {31'd0, mdio_oe}, {31'd0, e_oe});
      if (e_oe && mdio_oe)
        chk(m_isrd ? "R5 mdio_o" : "R4 mdio_o", {31'd0, mdio_o}, {31'd0, e_o});
    end
  end

  task automatic host_write(input bit sel, input logic [31:0] v);
    @(negedge clk);
    host_we = 1; host_sel = sel; host_wdata = v;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * FRAME_CLKS; i++) begin
      @(negedge clk);
      if (!m_start) break;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", host_rdata, 32'h0);
    chk("R9 reset oe", {31'd0, mdio_oe}, 32'd0);
    rst = 0;
    repeat (2) @(negedge clk);
    chk("R1 cmd default", host_rdata, 32'h0001_0000);
    host_sel = 1; repeat (2) @(negedge clk);
    chk("R1 data default", host_rdata, 32'h0);

    tag = "R2";
    host_write(1, 32'hFFFF_1234);
    host_write(0, 32'hFFEF_FFFF);
    host_sel = 0; repeat (2) @(negedge clk);
    chk("R2 reserved bits", host_rdata, 32'h0003_031F);

    tag = "R3";
    host_write(0, (32'd1 << 20) | (32'd1 << 16) | (32'd2 << 8) | 32'd5);
    tag = "R8";
    repeat (20) @(negedge clk);
    host_write(1, 32'h0000_BEEF);
    host_write(0, 32'h0002_0107);
    host_sel = 0;
    wait_idle();
    tag = "R3";
    repeat (3) @(negedge clk);
    host_sel = 1; repeat (2) @(negedge clk);

    tag = "R5";
    host_write(1, 32'h0000_5A5A);
    host_write(0, (32'd1 << 20) | (32'd2 << 16) | (32'd1 << 8) | 32'd31);
    host_sel = 1;
    wait_idle();
    repeat (4) @(negedge clk);

    tag = "R6";
    host_write(0, (32'd1 << 20) | (32'd0 << 16) | 32'd3);
    host_sel = 0; repeat (6) @(negedge clk);
    host_write(0, (32'd1 << 20) | (32'd3 << 16) | 32'd9);
    repeat (6) @(negedge clk);

    tag = "R4";
    host_write(1, 32'h0000_8001);
    host_write(0, (32'd1 << 20) | (32'd1 << 16) | (32'd3 << 8) | 32'd16);
    wait_idle();
    tag = "R5";
    host_write(0, (32'd1 << 20) | (32'd2 << 16) | (32'd0 << 8) | 32'd2);
    host_sel = 1;
    wait_idle();
    repeat (4) @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule